// File: doc/BRIEF.md
# CAN Error Flag and Code Capture Unit

This block sits beside a CAN protocol engine and turns its error event pulses into host-visible state. Two kinds of pulse arrive from the engine: category events (bus lock, overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning) and cause events that say which protocol rule was broken (ACK delimiter, bit error with dominant or recessive level, CRC, ACK, form, stuff). Each event latches a sticky flag. A cause event also raises the bus error flag, so the category register alone tells the host that something happened.

The host reaches the unit over a byte-wide register bus with registered read data. Flags are cleared one at a time by writing a zero to their bit; ones leave them alone, so a clear written as the inverse of a single bit touches only that flag. A mode bit in the cause register chooses between keeping only the latest error's causes or ORing every new cause into those already held. An enable register gates the category flags into a summary error bit, and a second enable gates that summary onto the interrupt output. Transmit and receive error counters come from the engine and are mirrored into read-only registers.

Top module: `can_errcap`

## Requirements
- R1: After synchronous reset every register reads 0x00, `bus_rdata` is 0x00 and `irq_err` is 0; the cause register starts in latest-error mode.
- R2: A pulse on `ev_state[i]` sets bit i+1 of the category flag register (address 0); that register's bits from 7 down to 1 are bus lock, overload sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning.
- R3: Writing address 0 clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged; a flag never sets without its event.
- R4: An event arriving in the same cycle as a write-zero clear of its flag wins, so the flag is set after that cycle.
- R5: The cause register (address 2) holds causes in bits 6..0: ACK delimiter (6), bit error dominant (5), bit error recessive (4), CRC (3), ACK (2), form (1), stuff (0), with `ev_code[i]` mapping to bit i; with bit 7 at 0 a new cause event replaces all of bits 6..0 with the new causes.
- R6: Bit 7 of address 2 is a read/write mode bit; at 1 new causes are ORed into those held; bits 6..0 clear by writing 0 and ignore written 1s.
- R7: Any cause event sets bit 0 (bus error) of the category flag register.
- R8: The flag enable register (address 1) is read/write with the same bit order as address 0; the status register (address 3) reads 0x20 when any flag is set together with its enable and 0x00 otherwise.
- R9: The interrupt enable register (address 4) keeps only bit 5 (other bits read 0); `irq_err` is high one cycle after the summary bit and the enable are both set, and low otherwise.
- R10: Addresses 5 and 6 return the transmit and receive error counter inputs captured one cycle earlier; writes to them have no effect.
- R11: `bus_rdata` shows, one cycle after an address is presented, the register contents before that edge; address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (3) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ev_state | input | 7 | Category event pulses, bit i maps to flag bit i+1 |
| ev_code | input | 7 | Cause event pulses, bit i maps to cause bit i |
| tec_in | input | CW (8) | Transmit error counter from the engine |
| rec_in | input | CW (8) | Receive error counter from the engine |
| irq_err | output | 1 | Summary error interrupt |

## Verification
Single category pulses at both ends of the flag register separate a correct bit mapping from a shifted one, and write-zero masks with a single zero bit versus all ones tell a per-bit clear from a whole-register clear. A clear written in the same cycle as an event shows which side wins. Cause pulses are sent in both modes so replacement and accumulation give different register values, and the enable pair is toggled one side at a time to show the interrupt needs both. A long stretch of mixed random writes and events is then compared each cycle against a behavioural model.

// File: rtl/can_errcap_pkg.sv
package can_errcap_pkg;
  localparam int DW       = 8;
  localparam int NSTATE   = 7;
  localparam int NCODE    = 7;
  localparam int ADR_FLAG = 0;
  localparam int ADR_FEN  = 1;
  localparam int ADR_CODE = 2;
  localparam int ADR_STAT = 3;
  localparam int ADR_IEN  = 4;
  localparam int ADR_TEC  = 5;
  localparam int ADR_REC  = 6;
  localparam int SUM_BIT  = 5;
  localparam int MODE_BIT = 7;
endpackage

// File: rtl/can_errcap_w0c.sv
module can_errcap_w0c #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  // Each bit: set wins over a write-zero clear; written ones are ignored.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)
        bit_q <= 1'b0;
      else if (set[i])
        bit_q <= 1'b1;
      else if (wr_hit && !wdata[i])
        bit_q <= 1'b0;
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/can_errcap_code.sv
module can_errcap_code #(
  parameter int NC = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [NC:0]   wdata,
  input  logic [NC-1:0] ev,
  output logic [NC-1:0] code_q,
  output logic          mode_q
);
  logic [NC-1:0] clr_mask;
  logic [NC-1:0] kept;
  logic [NC-1:0] code_n;
  logic          any_ev;

  assign any_ev   = |ev;
  assign clr_mask = wr_hit ? wdata[NC-1:0] : {NC{1'b1}};
  assign kept     = code_q & clr_mask;

  always_comb begin
    if (any_ev)
      code_n = mode_q ? (kept | ev) : ev;
    else
      code_n = kept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else begin
      code_q <= code_n;
      if (wr_hit)
        mode_q <= wdata[NC];
    end
  end
endmodule

// File: rtl/can_errcap_rdmux.sv
module can_errcap_rdmux #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] flag_rd,
  input  logic [DW-1:0] fen_rd,
  input  logic [DW-1:0] code_rd,
  input  logic [DW-1:0] stat_rd,
  input  logic [DW-1:0] ien_rd,
  input  logic [CW-1:0] tec_rd,
  input  logic [CW-1:0] rec_rd,
  output logic [DW-1:0] rdata
);
  import can_errcap_pkg::*;

  logic [DW-1:0] sel;

  always_comb begin
    if      (addr == AW'(ADR_FLAG)) sel = flag_rd;
    else if (addr == AW'(ADR_FEN))  sel = fen_rd;
    else if (addr == AW'(ADR_CODE)) sel = code_rd;
    else if (addr == AW'(ADR_STAT)) sel = stat_rd;
    else if (addr == AW'(ADR_IEN))  sel = ien_rd;
    else if (addr == AW'(ADR_TEC))  sel = DW'(tec_rd);
    else if (addr == AW'(ADR_REC))  sel = DW'(rec_rd);
    else                            sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/can_errcap.sv
module can_errcap
  import can_errcap_pkg::*;
#(
  parameter int AW = 3,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSTATE-1:0] ev_state,
  input  logic [NCODE-1:0]  ev_code,
  input  logic [CW-1:0]     tec_in,
  input  logic [CW-1:0]     rec_in,
  output logic              irq_err
);
  logic [DW-1:0]    flag_q;
  logic [DW-1:0]    fen_q;
  logic [NCODE-1:0] code_q;
  logic             mode_q;
  logic             ien_q;
  logic [CW-1:0]    tec_q;
  logic [CW-1:0]    rec_q;
  logic             sum_err;
  logic [DW-1:0]    flag_set;
  logic             hit_flag, hit_fen, hit_code, hit_ien;

  assign hit_flag = bus_we && (bus_addr == AW'(ADR_FLAG));
  assign hit_fen  = bus_we && (bus_addr == AW'(ADR_FEN));
  assign hit_code = bus_we && (bus_addr == AW'(ADR_CODE));
  assign hit_ien  = bus_we && (bus_addr == AW'(ADR_IEN));

  // Category events land above bit 0; bit 0 follows any cause event.
  assign flag_set = {ev_state, |ev_code};

  can_errcap_w0c #(.W(DW)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (hit_flag),
    .wdata  (bus_wdata),
    .set    (flag_set),
    .q      (flag_q)
  );

  can_errcap_code #(.NC(NCODE)) u_code (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (hit_code),
    .wdata  (bus_wdata[NCODE:0]),
    .ev     (ev_code),
    .code_q (code_q),
    .mode_q (mode_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fen_q   <= '0;
      ien_q   <= 1'b0;
      tec_q   <= '0;
      rec_q   <= '0;
      irq_err <= 1'b0;
    end else begin
      if (hit_fen) fen_q <= bus_wdata;
      if (hit_ien) ien_q <= bus_wdata[SUM_BIT];
      tec_q   <= tec_in;
      rec_q   <= rec_in;
      irq_err <= sum_err && ien_q;
    end
  end

  assign sum_err = |(flag_q & fen_q);

  can_errcap_rdmux #(.AW(AW), .DW(DW), .CW(CW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .flag_rd (flag_q),
    .fen_rd  (fen_q),
    .code_rd ({mode_q, code_q}),
    .stat_rd (DW'(sum_err) << SUM_BIT),
    .ien_rd  (DW'(ien_q) << SUM_BIT),
    .tec_rd  (tec_q),
    .rec_rd  (rec_q),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/can_errcap_chk.sv
module can_errcap_chk #(
  parameter int NS = 7,
  parameter int NC = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [NS-1:0] ev_state,
  input logic [NC-1:0] ev_code,
  input logic [NS:0]   flag_q,
  input logic [NC-1:0] code_q,
  input logic          mode_q,
  input logic          ien_q,
  input logic          irq_err
);
  AST_STATE_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (ev_state != '0) |=> ((flag_q[NS:1] & $past(ev_state)) == $past(ev_state))); // R2
  AST_CODE_SETS_BUSERR: assert property (@(posedge clk) disable iff (rst)
    (ev_code != '0) |=> flag_q[0]); // R7
  AST_NO_UNCAUSED_SET: assert property (@(posedge clk) disable iff (rst)
    (ev_state == '0 && ev_code == '0) |=> ((flag_q & ~$past(flag_q)) == '0)); // R3
  AST_LATEST_REPLACES: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && ev_code != '0) |=> (code_q == $past(ev_code))); // R5
  AST_ACCUM_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
    (mode_q && ev_code != '0) |=> ((code_q & $past(ev_code)) == $past(ev_code))); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!ien_q) |=> !irq_err); // R9
endmodule

bind can_errcap can_errcap_chk #(.NS(can_errcap_pkg::NSTATE), .NC(can_errcap_pkg::NCODE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_state (ev_state),
  .ev_code  (ev_code),
  .flag_q   (flag_q),
  .code_q   (code_q),
  .mode_q   (mode_q),
  .ien_q    (ien_q),
  .irq_err  (irq_err)
);

// File: tb/can_errcap_test.sv
module can_errcap_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [6:0] ev_state = '0;
  logic [6:0] ev_code = '0;
  logic [7:0] tec_in = '0;
  logic [7:0] rec_in = '0;
  wire  [7:0] bus_rdata;
  wire        irq_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_errcap uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_state(ev_state),
    .ev_code(ev_code), .tec_in(tec_in), .rec_in(rec_in), .irq_err(irq_err)
  );

  // Behavioural reference built from the requirements
  logic [7:0] m_flag, m_en, m_tec, m_rec, m_rd, nrd;
  logic [6:0] m_code;
  logic       m_mode, m_ie, m_irq, sum;

  always @(posedge clk) begin
    if (rst) begin
      m_flag = 0; m_en = 0; m_code = 0; m_mode = 0; m_ie = 0;
      m_tec = 0; m_rec = 0; m_rd = 0; m_irq = 0;
    end else begin
      sum = (m_flag & m_en) != 0;
      case (bus_addr)
        3'd0: nrd = m_flag;
        3'd1: nrd = m_en;
        3'd2: nrd = {m_mode, m_code};
        3'd3: nrd = sum ? 8'h20 : 8'h00;
        3'd4: nrd = m_ie ? 8'h20 : 8'h00;
        3'd5: nrd = m_tec;
        3'd6: nrd = m_rec;
        default: nrd = 8'h00;
      endcase
      m_rd  = nrd;
      m_irq = sum && m_ie;
      for (int b = 0; b < 8; b++) begin
        if (bus_we && bus_addr == 3'd0 && !bus_wdata[b]) m_flag[b] = 1'b0;
      end
      for (int b = 0; b < 7; b++) begin
        if (ev_state[b]) m_flag[b+1] = 1'b1;
      end
      if (ev_code != 0) m_flag[0] = 1'b1;
      if (bus_we && bus_addr == 3'd1) m_en = bus_wdata;
      if (ev_code != 0 && !m_mode) begin
        m_code = ev_code;
      end else begin
        for (int b = 0; b < 7; b++) begin
          if (bus_we && bus_addr == 3'd2 && !bus_wdata[b]) m_code[b] = 1'b0;
          if (ev_code[b]) m_code[b] = 1'b1;
        end
      end
      if (bus_we && bus_addr == 3'd2) m_mode = bus_wdata[7];
      if (bus_we && bus_addr == 3'd4) m_ie = bus_wdata[5];
      m_tec = tec_in;
      m_rec = rec_in;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 2;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL R11 model rdata: actual %02h expected %02h", bus_rdata, m_rd);
      end
      if (irq_err !== m_irq) begin
        errors++;
        $display("FAIL R9 model irq: actual %0b expected %0b", irq_err, m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_ev(input logic [2:0] a, input logic [7:0] d,
                       input logic [6:0] st, input logic [6:0] cd);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; ev_state = st; ev_code = cd;
    @(negedge clk);
    bus_we = 1'b0; ev_state = '0; ev_code = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_ev(a, d, 7'h00, 7'h00);
  endtask

  task automatic pulse(input logic [6:0] st, input logic [6:0] cd);
    @(negedge clk);
    ev_state = st; ev_code = cd;
    @(negedge clk);
    ev_state = '0; ev_code = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq after reset", {7'h0, irq_err}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register after reset", v, 8'h00);
    end

    // R2: category mapping at both ends
    pulse(7'b0000001, 7'h00);
    rd(3'd0, v); chk("R2 warning to bit 1", v, 8'h02);
    pulse(7'b1000000, 7'h00);
    rd(3'd0, v); chk("R2 bus lock to bit 7", v, 8'h82);

    // R3: write-zero clear per bit, ones ignored
    wr(3'd0, 8'hFD);
    rd(3'd0, v); chk("R3 single-bit clear", v, 8'h80);
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk("R3 write ones no effect", v, 8'h80);

    // R4: event beats simultaneous clear
    wr_ev(3'd0, 8'h00, 7'b0000010, 7'h00);
    rd(3'd0, v); chk("R4 event wins over clear", v, 8'h04);

    // R5 and R7: latest-error mode
    pulse(7'h00, 7'h08);
    rd(3'd2, v); chk("R5 CRC cause latched", v, 8'h08);
    rd(3'd0, v); chk("R7 bus error flag set", v, 8'h05);
    pulse(7'h00, 7'h01);
    rd(3'd2, v); chk("R5 new cause replaces old", v, 8'h01);

    // R6: accumulate mode
    wr(3'd2, 8'h80);
    rd(3'd2, v); chk("R6 mode set, causes cleared", v, 8'h80);
    pulse(7'h00, 7'h40);
    pulse(7'h00, 7'h02);
    rd(3'd2, v); chk("R6 causes accumulate", v, 8'hC2);
    wr(3'd2, 8'hBF);
    rd(3'd2, v); chk("R6 single cause clear", v, 8'h82);

    // R8: enables and summary status
    wr(3'd0, 8'h00);
    rd(3'd3, v); chk("R8 no flags no summary", v, 8'h00);
    pulse(7'h00, 7'h04);
    rd(3'd3, v); chk("R8 flag without enable", v, 8'h00);
    wr(3'd1, 8'h01);
    rd(3'd3, v); chk("R8 flag with enable", v, 8'h20);
    rd(3'd1, v); chk("R8 enable readback", v, 8'h01);
    chk("R9 irq held off by interrupt enable", {7'h0, irq_err}, 8'h00);

    // R9: interrupt enable and output
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R9 only bit 5 kept", v, 8'h20);
    chk("R9 irq asserted", {7'h0, irq_err}, 8'h01);
    wr(3'd1, 8'hFE);
    rd(3'd3, v); chk("R8 enable removed", v, 8'h00);
    chk("R9 irq drops", {7'h0, irq_err}, 8'h00);

    // R10: counter mirrors
    @(negedge clk);
    tec_in = 8'h5A; rec_in = 8'hA5;
    @(posedge clk);
    rd(3'd5, v); chk("R10 transmit counter", v, 8'h5A);
    rd(3'd6, v); chk("R10 receive counter", v, 8'hA5);
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R10 write ignored", v, 8'h5A);

    // R11: unused address
    rd(3'd7, v); chk("R11 unused address", v, 8'h00);

    // Mixed traffic, compared against the model every cycle
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      bus_we    = ($urandom % 3) == 0;
      bus_addr  = 3'($urandom);
      bus_wdata = 8'($urandom);
      ev_state  = (($urandom % 4) == 0) ? 7'($urandom) : 7'h00;
      ev_code   = (($urandom % 4) == 0) ? 7'($urandom) : 7'h00;
      tec_in    = 8'($urandom);
      rec_in    = 8'($urandom);
    end
    @(negedge clk);
    bus_we = 1'b0; ev_state = '0; ev_code = '0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule